// File: doc/BRIEF.md
# Disk Sector Serialiser with Single-Sector Buffer

This block sits between a host and the serial data channel of a hard disk. It follows the rotation of the platter by counting the index and sector marks the drive reports, so it always knows which sector is passing under the heads. The host names a sector and a direction. The block then waits for that sector to arrive and moves exactly one sector between the serial lines and a small buffer. The host fills or empties that buffer through a port of its own.

All serial activity is paced by a bit strobe that the drive supplies. On a write, the block drives the data bits and a trailing checksum onto the write-data line and holds the write gate high. On a read, it assembles the incoming bits into bytes in the buffer and checks the trailing checksum. The buffer holds only one sector. The host therefore runs one command at a time and collects the result after the done flag rises and before it issues the next command.

Each sector carries SECT_BYTES data bytes followed by a 16-bit CRC. The CRC uses the generator x^16+x^12+x^5+1, starts from all ones, has no final inversion, and is sent MSB first. The block corrects no errors.

Top module: `sector_serdes`

## Requirements
- R1: `head_sector` is 0 after reset. It becomes 0 on the cycle after `index_pulse`, which has priority over a simultaneous `sector_pulse`. It increments by one (wrapping at 2^SECT_W) on the cycle after each `sector_pulse`, and otherwise holds.
- R2: A `cmd_valid` sampled while `busy` is low is accepted. `busy` is high from the next cycle, and `done` and `crc_err` are cleared in that same cycle. `cmd_write`=1 selects a write and 0 selects a read.
- R3: After it accepts a command, the block ignores bit strobes and keeps `ser_wg` low until it sees an index or sector mark whose updated count equals `cmd_sector`. It takes bits only from the cycle after that mark.
- R4: On a write, `ser_wg` is high for exactly SECT_BYTES*8+16 strobes. It goes low on the clock edge that consumes the last CRC bit.
- R5: On a write, `ser_wd` presents buffer byte 0 first, each byte MSB first, and then the 16-bit CRC MSB first. The CRC uses generator 0x1021 with preset 0xFFFF and is computed over the data bits.
- R6: On a read, the bits sampled from `ser_rd` on each strobe are stored MSB first. The k-th received byte lands at buffer address k.
- R7: At the end of a read, `crc_err` is 1 if the received CRC differs from the CRC computed over the received data, and 0 otherwise. `done` rises in both cases.
- R8: While `busy` is high, `host_we` and `cmd_valid` are ignored.
- R9: `host_rdata` shows the buffer byte at `host_addr` one cycle after the address is applied. A host write takes effect on the next clock edge.
- R10: `done` rises on the same edge on which `busy` falls at the end of a transfer. It stays high until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| index_pulse | input | 1 | One-cycle mark at the start of a revolution |
| sector_pulse | input | 1 | One-cycle mark at the start of each following sector |
| ser_strobe | input | 1 | One-cycle bit strobe from the drive |
| ser_rd | input | 1 | Serial read data, sampled on the strobe |
| ser_wd | output | 1 | Serial write data |
| ser_wg | output | 1 | Write gate |
| cmd_valid | input | 1 | Command request |
| cmd_write | input | 1 | 1 = write sector, 0 = read sector |
| cmd_sector | input | SECT_W | Target sector number |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last command finished |
| crc_err | output | 1 | Last read had a CRC mismatch |
| head_sector | output | SECT_W | Sector currently under the heads |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | $clog2(SECT_BYTES) | Host buffer address |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Host buffer read data |

## Verification
The hardest situations to reach are the protection cases: a host write or a second command that arrives in the middle of a transfer, and the cycle on which the write gate drops. The bench shrinks the sector to a few bytes. It steers the rotation marks so the target arrives only after several non-matching marks with strobes in between, and then injects a host write and a command between two strobes of a live transfer. The read sweep covers several sectors and data patterns. It ends with a stream whose final CRC bit is flipped.

// File: rtl/ssd_pkg.sv
package ssd_pkg;

    localparam int unsigned CRC_W      = 16;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_XFER
    } phase_e;

    // One serial step of the checksum, MSB-first feed
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/ssd_tracker.sv
module ssd_tracker #(
    parameter int unsigned SECT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              index_pulse,
    input  logic              sector_pulse,
    output logic [SECT_W-1:0] head_sector,
    output logic [SECT_W-1:0] next_sector,
    output logic              start_evt
);

    assign start_evt   = index_pulse | sector_pulse;
    assign next_sector = index_pulse  ? '0 :
                         sector_pulse ? head_sector + SECT_W'(1) : head_sector;

    always_ff @(posedge clk) begin
        if (rst) head_sector <= '0;
        else     head_sector <= next_sector;
    end

endmodule

// File: rtl/ssd_crc.sv
module ssd_crc (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        shift_en,
    input  logic        bit_in,
    output logic [15:0] crc,
    output logic [15:0] crc_next
);
    import ssd_pkg::*;

    assign crc_next = crc16_step(crc, bit_in);

    always_ff @(posedge clk) begin
        if (rst || clear) crc <= CRC_PRESET;
        else if (shift_en) crc <= crc_next;
    end

endmodule

// File: rtl/ssd_buffer.sv
module ssd_buffer #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic          s_we,
    input  logic [AW-1:0] s_addr,
    input  logic [7:0]    s_wdata,
    output logic [7:0]    s_rdata
);

    logic [7:0] mem [DEPTH];

    // The two write ports never overlap: the host side is gated off during a transfer
    always_ff @(posedge clk) begin
        if (h_we)      mem[h_addr] <= h_wdata;
        else if (s_we) mem[s_addr] <= s_wdata;
        h_rdata <= mem[h_addr];
    end

    assign s_rdata = mem[s_addr];

endmodule

// File: rtl/sector_serdes.sv
module sector_serdes #(
    parameter int unsigned SECT_BYTES = 256,
    parameter int unsigned SECT_W     = 5,
    localparam int unsigned AW        = $clog2(SECT_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              index_pulse,
    input  logic              sector_pulse,
    input  logic              ser_strobe,
    input  logic              ser_rd,
    output logic              ser_wd,
    output logic              ser_wg,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [SECT_W-1:0] cmd_sector,
    output logic              busy,
    output logic              done,
    output logic              crc_err,
    output logic [SECT_W-1:0] head_sector,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    import ssd_pkg::*;

    localparam int unsigned DATA_BITS  = SECT_BYTES * 8;
    localparam int unsigned TOTAL_BITS = DATA_BITS + CRC_W;
    localparam int unsigned CW         = $clog2(TOTAL_BITS + 1);

    phase_e            phase;
    logic              job_wr;
    logic [SECT_W-1:0] job_sec;
    logic [CW-1:0]     bit_idx;
    logic [6:0]        rx_sh;

    logic [SECT_W-1:0] next_sector;
    logic              start_evt;
    logic [15:0]       crc, crc_next;
    logic [7:0]        s_rdata;

    logic        accept, xfer, take, in_data, last_bit, tx_bit, line_bit, s_we;
    logic [2:0]  bit_sel;
    logic [AW-1:0] byte_addr;

    ssd_tracker #(.SECT_W(SECT_W)) u_track (
        .clk(clk), .rst(rst),
        .index_pulse(index_pulse), .sector_pulse(sector_pulse),
        .head_sector(head_sector), .next_sector(next_sector), .start_evt(start_evt)
    );

    assign accept    = cmd_valid && (phase == PH_IDLE);
    assign xfer      = (phase == PH_XFER);
    assign take      = xfer && ser_strobe;
    assign in_data   = bit_idx < CW'(DATA_BITS);
    assign last_bit  = bit_idx == CW'(TOTAL_BITS - 1);
    assign bit_sel   = bit_idx[2:0];
    assign byte_addr = bit_idx[AW+2:3];
    assign tx_bit    = in_data ? s_rdata[3'd7 - bit_sel] : crc[15];
    assign line_bit  = job_wr ? tx_bit : ser_rd;
    assign s_we      = take && !job_wr && in_data && (bit_sel == 3'd7);

    ssd_crc u_crc (
        .clk(clk), .rst(rst), .clear(accept), .shift_en(take),
        .bit_in(line_bit), .crc(crc), .crc_next(crc_next)
    );

    ssd_buffer #(.DEPTH(SECT_BYTES)) u_buf (
        .clk(clk),
        .h_we(host_we && (phase == PH_IDLE)), .h_addr(host_addr),
        .h_wdata(host_wdata), .h_rdata(host_rdata),
        .s_we(s_we), .s_addr(byte_addr), .s_wdata({rx_sh, ser_rd}), .s_rdata(s_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            job_wr  <= 1'b0;
            job_sec <= '0;
            bit_idx <= '0;
            rx_sh   <= '0;
            done    <= 1'b0;
            crc_err <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase   <= PH_WAIT;
                    job_wr  <= cmd_write;
                    job_sec <= cmd_sector;
                    done    <= 1'b0;
                    crc_err <= 1'b0;
                end
                PH_WAIT: if (start_evt && next_sector == job_sec) begin
                    phase   <= PH_XFER;
                    bit_idx <= '0;
                end
                PH_XFER: if (take) begin
                    bit_idx <= bit_idx + CW'(1);
                    rx_sh   <= {rx_sh[5:0], ser_rd};
                    if (last_bit) begin
                        phase   <= PH_IDLE;
                        done    <= 1'b1;
                        // Feeding the received checksum through leaves zero on a match
                        crc_err <= !job_wr && (crc_next != 16'h0000);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (phase != PH_IDLE);
    assign ser_wg = xfer && job_wr;
    assign ser_wd = ser_wg ? tx_bit : 1'b0;

endmodule

// File: rtl/sector_serdes_chk.sv
module sector_serdes_chk #(
    parameter int unsigned SECT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              index_pulse,
    input logic              sector_pulse,
    input logic              cmd_valid,
    input logic              ser_strobe,
    input logic              busy,
    input logic              done,
    input logic              crc_err,
    input logic              ser_wg,
    input logic [SECT_W-1:0] head_sector
);

    // R1
    index_zero_chk: assert property (@(posedge clk) disable iff (rst)
        index_pulse |=> head_sector == '0);

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!index_pulse && !sector_pulse) |=> $stable(head_sector));

    // R2
    cmd_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid) |=> busy);

    // R2
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R4
    gate_busy_chk: assert property (@(posedge clk) disable iff (rst)
        ser_wg |-> busy);

    // R4
    gate_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_wg) |-> $past(ser_strobe));

    // R7
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        crc_err |-> done);

    // R10
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(busy));

endmodule

bind sector_serdes sector_serdes_chk #(.SECT_W(SECT_W)) u_chk (
    .clk(clk), .rst(rst), .index_pulse(index_pulse), .sector_pulse(sector_pulse),
    .cmd_valid(cmd_valid), .ser_strobe(ser_strobe), .busy(busy), .done(done),
    .crc_err(crc_err), .ser_wg(ser_wg), .head_sector(head_sector)
);

// File: tb/sector_serdes_test.sv
module sector_serdes_test;

    localparam int SB = 4;
    localparam int SW = 3;
    localparam int AWB = $clog2(SB);
    localparam int DB = SB * 8;
    localparam int TB = DB + 16;

    logic clk = 0, rst = 1;
    logic index_pulse = 0, sector_pulse = 0, ser_strobe = 0, ser_rd = 0;
    logic ser_wd, ser_wg, busy, done, crc_err;
    logic cmd_valid = 0, cmd_write = 0;
    logic [SW-1:0] cmd_sector = '0, head_sector;
    logic host_we = 0;
    logic [AWB-1:0] host_addr = '0;
    logic [7:0] host_wdata = '0, host_rdata;

    int checks = 0, fails = 0;
    logic [7:0] pat [SB];
    logic stream [TB];

    always #4 clk = ~clk;

    sector_serdes #(.SECT_BYTES(SB), .SECT_W(SW)) uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Builds the expected serial stream: data MSB first, then CRC MSB first
    task automatic build_stream();
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < DB; i++) begin
            logic b = pat[i/8][7 - (i % 8)];
            stream[i] = b;
            c = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
        end
        for (int i = 0; i < 16; i++) stream[DB + i] = c[15 - i];
    endtask

    task automatic pulse(input bit idx);
        index_pulse = idx; sector_pulse = !idx;
        @(negedge clk);
        index_pulse = 0; sector_pulse = 0;
    endtask

    task automatic strobe(input logic b, output logic wd, output logic wg);
        ser_rd = b; ser_strobe = 1; wd = ser_wd; wg = ser_wg;
        @(negedge clk); ser_strobe = 0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic hwrite(input int a, input int d);
        host_we = 1; host_addr = AWB'(a); host_wdata = 8'(d);
        @(negedge clk); host_we = 0;
    endtask

    task automatic hread(input int a, output logic [7:0] d);
        host_addr = AWB'(a);
        @(negedge clk); d = host_rdata;
    endtask

    task automatic command(input bit wr, input int s);
        cmd_valid = 1; cmd_write = wr; cmd_sector = SW'(s);
        @(negedge clk); cmd_valid = 0;
    endtask

    // Bring the target sector under the heads; strobes in between must be ignored (R3)
    task automatic seek_to(input int s);
        logic wd, wg;
        pulse(1);
        for (int k = 1; k <= s; k++) begin
            strobe(1'b1, wd, wg);
            check(wg == 0 && busy, "R3 wait gate", wg, 0);
            pulse(0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
    end

    initial begin
        logic wd, wg;
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !done && !crc_err && !ser_wg, "R2 reset flags", {busy, done, crc_err, ser_wg}, 0);
        check(head_sector == 0, "R1 reset count", head_sector, 0);

        // R1: counter sweep with wrap, index restart and index priority
        pulse(1);
        for (int k = 1; k <= 10; k++) begin
            pulse(0);
            check(head_sector == SW'(k), "R1 count", head_sector, k % 8);
        end
        index_pulse = 1; sector_pulse = 1;
        @(negedge clk); index_pulse = 0; sector_pulse = 0;
        check(head_sector == 0, "R1 index priority", head_sector, 0);

        // R9: host fill and readback
        for (int k = 0; k < SB; k++) begin
            pat[k] = 8'(k * 37 + 5);
            hwrite(k, pat[k]);
        end
        for (int k = 0; k < SB; k++) begin
            hread(k, rb);
            check(rb == pat[k], "R9 host readback", rb, pat[k]);
        end

        // R4 R5: write to sector 3
        build_stream();
        command(1, 3);
        check(busy && !done, "R2 accept", {busy, done}, 2);
        seek_to(3);
        hwrite(0, 8'hAA);           // R8: ignored while busy
        command(0, 5);              // R8: ignored while busy
        for (int i = 0; i < TB; i++) begin
            strobe(1'b0, wd, wg);
            check(wg == 1, "R4 gate high", wg, 1);
            check(wd == stream[i], "R5 write bit", wd, stream[i]);
        end
        check(!ser_wg, "R4 gate released", ser_wg, 0);
        check(done && !busy && !crc_err, "R10 done after write", {done, busy, crc_err}, 4);
        repeat (20) @(negedge clk);
        check(!busy && done, "R8 command ignored", {busy, done}, 1);
        hread(0, rb);
        check(rb == pat[0], "R8 host write ignored", rb, pat[0]);

        // R6 R7: read sweep, last pass with a flipped CRC bit
        for (int t = 0; t < 4; t++) begin
            int s = (t * 3 + 1) % 8;
            bit bad = (t == 3);
            for (int k = 0; k < SB; k++) pat[k] = 8'(t * 50 + k * 17 + 3);
            build_stream();
            if (bad) stream[TB-1] = !stream[TB-1];
            command(0, s);
            check(!done && !crc_err, "R2 flags cleared", {done, crc_err}, 0);
            seek_to(s);
            for (int i = 0; i < TB; i++) begin
                strobe(stream[i], wd, wg);
                check(wg == 0, "R3 no gate on read", wg, 0);
            end
            check(done && !busy, "R7 done", {done, busy}, 2);
            check(crc_err == bad, "R7 crc status", crc_err, bad);
            for (int k = 0; k < SB; k++) begin
                hread(k, rb);
                check(rb == pat[k], "R6 read byte", rb, pat[k]);
            end
        end
        summary();
    end

endmodule